// File: doc/BRIEF.md
# Conditional trap compare unit

This unit decides whether a conditional trap instruction fires. It takes two operands, a five-bit condition mask and a select between word and doubleword width. All five relations between the operands are evaluated at once: signed less, signed greater, equal, unsigned less and unsigned greater. The unit raises a trap when any relation that the mask enables is true.

The decision is registered. A valid strobe qualifies the inputs, and the trap request appears as a one-cycle pulse in the cycle after the strobe. The exception class and reason code that go with a trap are constant outputs, so a downstream exception unit can pick them up without further decoding. In word mode only the low 32 bits of each operand take part.

Top module: `trap_cmp_unit`

## Requirements
- R1: Mask bit 4 (value 0x10) enables a trap when opA is less than opB as a signed number.
- R2: Mask bit 3 (value 0x08) enables a trap when opA is greater than opB as a signed number.
- R3: Mask bit 2 (value 0x04) enables a trap when opA equals opB.
- R4: Mask bit 1 (value 0x02) enables a trap on unsigned less-than, and mask bit 0 (value 0x01) enables a trap on unsigned greater-than.
- R5: The trap fires when at least one enabled relation holds, and it never fires when the mask is zero.
- R6: When wordMode is 1, only bits 31:0 of each operand are compared, as signed or unsigned 32-bit values. Bits 63:32 have no effect.
- R7: trapReq is high for exactly the one cycle that follows a cycle in which inValid was high and the trap condition held. It is never high in a cycle that does not follow a valid input.
- R8: While rst (synchronous, active high) is asserted, trapReq is cleared, and it is 0 in the first cycle after reset.
- R9: excClass is the constant 4'h6 (program class), and excCode is the constant 8'h02 (trap reason).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Qualifies operands and mask in this cycle |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| condMask | input | 5 | Trap condition enables |
| wordMode | input | 1 | 1 selects a 32-bit comparison |
| trapReq | output | 1 | Registered one-cycle trap request |
| excClass | output | 4 | Constant exception class |
| excCode | output | 8 | Constant trap reason code |

## Verification
The bench uses operands whose signed and unsigned orderings disagree, such as all-ones against one. A design that mixed up the signed and unsigned comparators, or swapped two mask bits, would trap on the wrong mask bit. Word-mode cases put operands that differ only above bit 31, or that have opposite orderings above and below it, against every mask bit. A design that leaked the high half into the comparison would trap or stay silent in the wrong cases. Further cases cover a zero mask, a true relation without inValid, and back-to-back valid inputs, which would expose a pulse that lasts too long, a pulse raised without a strobe, or a sticky output.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;
  localparam int unsigned MASK_W    = 5;
  localparam int unsigned CLASS_W   = 4;
  localparam int unsigned CODE_W    = 8;
  localparam logic [CLASS_W-1:0] PROGRAM_CLASS = 4'h6;
  localparam logic [CODE_W-1:0]  TRAP_REASON   = 8'h02;

  // Member order matches the mask bits 4 down to 0.
  typedef struct packed {
    logic sLt;
    logic sGt;
    logic eq;
    logic uLt;
    logic uGt;
  } relFlags_t;

  typedef struct packed {
    logic evalEn;
    logic clrOut;
  } ctrlStrobes_t;
endpackage

// File: rtl/trap_cmp_datapath.sv
module trap_cmp_datapath
  import trap_cmp_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [MASK_W-1:0] condMask,
  input  logic              wordMode,
  input  ctrlStrobes_t      strobes,
  output logic              hit
);
  localparam int unsigned EXT_W = DATA_W - WORD_W;

  logic [DATA_W-1:0] sA, sB, uA, uB;
  relFlags_t         rel;
  logic [MASK_W-1:0] enabledRel;

  generate
    if (EXT_W > 0) begin : g_narrow
      always_comb begin
        if (wordMode) begin
          sA = {{EXT_W{opA[WORD_W-1]}}, opA[WORD_W-1:0]};
          sB = {{EXT_W{opB[WORD_W-1]}}, opB[WORD_W-1:0]};
          uA = {{EXT_W{1'b0}}, opA[WORD_W-1:0]};
          uB = {{EXT_W{1'b0}}, opB[WORD_W-1:0]};
        end else begin
          sA = opA;
          sB = opB;
          uA = opA;
          uB = opB;
        end
      end
    end else begin : g_full
      assign sA = opA;
      assign sB = opB;
      assign uA = opA;
      assign uB = opB;
    end
  endgenerate

  always_comb begin
    rel.sLt = $signed(sA) < $signed(sB);
    rel.sGt = $signed(sA) > $signed(sB);
    rel.eq  = uA == uB;
    rel.uLt = uA < uB;
    rel.uGt = uA > uB;
  end

  assign enabledRel = condMask & rel;
  assign hit = strobes.evalEn & ~strobes.clrOut & (|enabledRel);

  // R3: equality excludes every ordering relation
  a_r3_eq_exclusive: assert property (@(posedge clk) disable iff (rst)
    rel.eq |-> !(rel.sLt || rel.sGt || rel.uLt || rel.uGt));

  // R1, R2: exactly one signed relation holds
  a_r1_signed_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones({rel.sLt, rel.sGt, rel.eq}) == 1);

  // R4: exactly one unsigned relation holds
  a_r4_unsigned_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones({rel.uLt, rel.uGt, rel.eq}) == 1);
endmodule

// File: rtl/trap_cmp_ctrl.sv
module trap_cmp_ctrl
  import trap_cmp_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         hit,
  output ctrlStrobes_t strobes,
  output logic         trapReq
);
  always_comb begin
    strobes.evalEn = inValid;
    strobes.clrOut = rst;
  end

  always_ff @(posedge clk) begin
    if (rst) trapReq <= 1'b0;
    else     trapReq <= hit;
  end

  // R7: no request without a valid input in the previous cycle
  a_r7_needs_valid: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !trapReq);

  // R8: the request is clear in the cycle after reset
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> !trapReq);
endmodule

// File: rtl/trap_cmp_unit.sv
module trap_cmp_unit
  import trap_cmp_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [MASK_W-1:0] condMask,
  input  logic              wordMode,
  output logic              trapReq,
  output logic [CLASS_W-1:0] excClass,
  output logic [CODE_W-1:0]  excCode
);
  ctrlStrobes_t strobes;
  logic         hit;

  trap_cmp_datapath #(.DATA_W(DATA_W), .WORD_W(WORD_W)) i_datapath (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .condMask(condMask),
    .wordMode(wordMode), .strobes(strobes), .hit(hit)
  );

  trap_cmp_ctrl i_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .hit(hit),
    .strobes(strobes), .trapReq(trapReq)
  );

  assign excClass = PROGRAM_CLASS;
  assign excCode  = TRAP_REASON;

  // R5: a zero mask never produces a request
  a_r5_zero_mask: assert property (@(posedge clk) disable iff (rst)
    (inValid && condMask == '0) |=> !trapReq);

  // R6: in word mode, equal low halves with equality enabled always trap
  a_r6_word_eq: assert property (@(posedge clk) disable iff (rst)
    (inValid && wordMode && condMask[2] && opA[WORD_W-1:0] == opB[WORD_W-1:0])
      |=> trapReq);
endmodule

// File: tb/test_trap_cmp_unit.sv
module test_trap_cmp_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [63:0] opA, opB;
  logic [4:0]  condMask;
  logic        wordMode;
  logic        trapReq;
  logic [3:0]  excClass;
  logic [7:0]  excCode;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_cmp_unit i_trap_cmp_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .condMask(condMask), .wordMode(wordMode), .trapReq(trapReq),
    .excClass(excClass), .excCode(excCode)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit expect_trap(input logic [63:0] a, input logic [63:0] b,
                                     input logic [4:0] m, input logic w);
    longint sa, sb;
    logic [63:0] ua, ub;
    if (w) begin
      sa = longint'($signed(a[31:0])); sb = longint'($signed(b[31:0]));
      ua = {32'd0, a[31:0]};          ub = {32'd0, b[31:0]};
    end else begin
      sa = $signed(a); sb = $signed(b); ua = a; ub = b;
    end
    return (m[4] && sa < sb) || (m[3] && sa > sb) || (m[2] && ua == ub) ||
           (m[1] && ua < ub) || (m[0] && ua > ub);
  endfunction

  // Apply one valid input, check the pulse, then check it drops.
  task automatic run_case(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic [4:0] m, input logic w);
    bit e;
    e = expect_trap(a, b, m, w);
    @(negedge clk);
    opA = a; opB = b; condMask = m; wordMode = w; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(req, trapReq, e);
    @(negedge clk);
    check({req, " R7 pulse ends"}, trapReq, 0);
  endtask

  task automatic test_reset();
    rst = 1'b1; inValid = 1'b1; opA = 0; opB = 0; condMask = 5'h04; wordMode = 0;
    repeat (3) @(negedge clk);
    check("R8 held in reset", trapReq, 0);
    inValid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R8 after reset", trapReq, 0);
  endtask

  task automatic test_constants();
    check("R9 class", excClass, 4'h6);
    check("R9 code", excCode, 8'h02);
  endtask

  task automatic test_single_bits();
    // -1 vs 1: signed less, unsigned greater
    run_case("R1 slt true",  64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h10, 0);
    run_case("R2 sgt false", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h08, 0);
    run_case("R2 sgt true",  64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h08, 0);
    run_case("R3 eq true",   64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h04, 0);
    run_case("R3 eq false",  64'd5, 64'd6, 5'h04, 0);
    run_case("R4 ult false", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h02, 0);
    run_case("R4 ugt true",  64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h01, 0);
    run_case("R4 ult true",  64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h02, 0);
    run_case("R1 slt false eq", 64'd7, 64'd7, 5'h10, 0);
  endtask

  task automatic test_combos();
    run_case("R5 zero mask", 64'd1, 64'd2, 5'h00, 0);
    run_case("R5 zero mask eq", 64'd3, 64'd3, 5'h00, 0);
    run_case("R5 or of lt ops", 64'd3, 64'd9, 5'h12, 0);
    run_case("R5 all but eq on eq", 64'd3, 64'd3, 5'h1B, 0);
    run_case("R5 full mask", 64'd3, 64'd4, 5'h1F, 0);
  endtask

  task automatic test_word_mode();
    // Differ only above bit 31
    run_case("R6 eq ignores high", 64'hAAAA_0000_0000_0005, 64'h5555_0000_0000_0005, 5'h04, 1);
    run_case("R6 no ult from high", 64'h0000_0000_0000_0005, 64'hFFFF_0000_0000_0005, 5'h1B, 1);
    // Low half 0x80000000 is negative as a signed word
    run_case("R6 word slt", 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 5'h10, 1);
    run_case("R6 word ugt", 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 5'h01, 1);
    run_case("R6 dword sgt", 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 5'h08, 0);
    // High halves ordered opposite to the low halves
    run_case("R6 opposite halves", 64'h0000_0000_FFFF_FFF0, 64'hFFFF_FFFF_0000_0010, 5'h02, 1);
  endtask

  task automatic test_no_valid();
    @(negedge clk);
    opA = 64'd1; opB = 64'd1; condMask = 5'h1F; wordMode = 0; inValid = 1'b0;
    @(negedge clk);
    check("R7 no valid no trap", trapReq, 0);
    @(negedge clk);
    check("R7 still no trap", trapReq, 0);
  endtask

  task automatic test_back_to_back();
    @(negedge clk);
    opA = 64'd1; opB = 64'd1; condMask = 5'h04; wordMode = 0; inValid = 1'b1;
    @(negedge clk);
    check("R7 b2b first", trapReq, 1);
    opA = 64'd2;
    @(negedge clk);
    check("R7 b2b second false", trapReq, 0);
    opA = 64'd1;
    @(negedge clk);
    inValid = 1'b0;
    check("R7 b2b third", trapReq, 1);
    @(negedge clk);
    check("R7 b2b drop", trapReq, 0);
  endtask

  initial begin
    test_reset();
    test_constants();
    test_single_bits();
    test_combos();
    test_word_mode();
    test_no_valid();
    test_back_to_back();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule